// File: doc/BRIEF.md
# Command-Driven I2C Byte Master

This block is the master side of an I2C port, run one step at a time by the processor that owns it. Each bus condition has its own one-cycle request input: START, repeated START, STOP, receive one byte, or the acknowledge bit after a received byte. A write to the transmit register sends one byte and clocks the slave's acknowledge back in. Every request shows a pending status flag. The flag clears by itself when the sequence ends, so software issues a request, waits for the flag to drop, and then issues the next one.

Timing comes from a reload counter loaded from a preset register. One step lasts P+1 clock cycles, where P is the preset value. A START takes two steps and a STOP three. A repeated START takes four. Each data or acknowledge bit takes three steps: place SDA, release SCL, then sample and pull SCL low. A slave that holds SCL low stretches the current step. Both bus lines are open-drain: the block drives a line low through an enable and reads the real level back. Misuse and conflicts are recorded in sticky flags: a rejected transmit write, a receive overrun, and a bus collision.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, both line enables are 0 (released), the step preset reads 0, the transmit register reads 0xFF, the receive register reads 0x00, and every pending and status flag is 0.
- R2: `go_start` while idle pulls SDA low while SCL is high, then pulls SCL low. `start_pend` is 1 throughout and clears after exactly 2 steps, leaving both enables at 1.
- R3: `tx_we` while idle, with no request in the same cycle, loads `tx_q` and sends it MSB first. `tx_active` and `tx_full` are both 1 at the start. `tx_full` drops after the eighth data bit. `tx_active` stays 1 through the ninth (acknowledge) clock and clears after exactly 27 steps. SDA changes only while the block holds SCL low.
- R4: `nack_seen` takes the SDA level sampled in the ninth clock of a transmit: 0 means the slave acknowledged, 1 means it did not.
- R5: `go_recv` clocks in 8 bits MSB first in 24 steps, with SDA released. It then writes them to `rx_q` and sets `rx_full`. A one-cycle `rx_re` clears `rx_full`.
- R6: `go_ack` latches `ack_level` and puts that level on SDA for one clock (0 = acknowledge, 1 = no acknowledge). `ack_pend` clears after 3 steps.
- R7: `go_restart` releases SDA, releases SCL, pulls SDA low with SCL high, then pulls SCL low, in 4 steps. `go_stop` pulls SDA low, releases SCL, then releases SDA with SCL high, in 3 steps, leaving both enables at 0.
- R8: A `tx_we` while any sequence runs, or in the same cycle as a request, sets `wr_clash`. The write is discarded: `tx_q` and the byte on the bus are unchanged.
- R9: If a received byte completes while `rx_full` is still 1 and no `rx_re` occurs in that cycle, `rx_overrun` is set. The new byte replaces the old one in `rx_q`.
- R10: `bus_clash` is set when SDA is sampled low in a clock where the block released SDA, during a transmit data bit or an acknowledge sequence. The sequence itself runs to its end.
- R11: One step is P+1 cycles, where P is loaded through `brg_we`. A normal SCL high phase lasts P+1 cycles. While SCL is released but reads low, the step count pauses and SCL stays released.
- R12: `flag_clr` clears `wr_clash`, `rx_overrun` and `bus_clash`.
- R13: Requests that arrive while a sequence is running are ignored: no pending flag rises and nothing appears on the bus. When several requests arrive together while idle, they are served in the order START, repeated START, STOP, receive, acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| brg_we | input | 1 | Write strobe for the step preset |
| brg_wdata | input | BRG_W | New step preset value |
| brg_q | output | BRG_W | Current step preset |
| tx_we | input | 1 | Transmit register write; starts a byte send |
| tx_wdata | input | 8 | Byte to send |
| tx_q | output | 8 | Transmit register contents |
| rx_re | input | 1 | Receive register read strobe |
| rx_q | output | 8 | Last received byte |
| go_start | input | 1 | Request a START |
| go_restart | input | 1 | Request a repeated START |
| go_stop | input | 1 | Request a STOP |
| go_recv | input | 1 | Request a one-byte receive |
| go_ack | input | 1 | Request an acknowledge clock |
| ack_level | input | 1 | SDA level for the acknowledge clock |
| flag_clr | input | 1 | Clear the sticky error flags |
| start_pend | output | 1 | START in progress |
| restart_pend | output | 1 | Repeated START in progress |
| stop_pend | output | 1 | STOP in progress |
| recv_pend | output | 1 | Receive in progress |
| ack_pend | output | 1 | Acknowledge clock in progress |
| nack_seen | output | 1 | Acknowledge level from the last transmit |
| tx_active | output | 1 | Transmit (8 bits plus acknowledge) in progress |
| tx_full | output | 1 | Transmit register holds unsent data |
| rx_full | output | 1 | Receive register holds an unread byte |
| wr_clash | output | 1 | Transmit write was rejected |
| rx_overrun | output | 1 | Byte arrived while the previous byte was unread |
| bus_clash | output | 1 | Released SDA was read low |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |

## Verification
The properties assume the bus lines read high whenever nothing pulls them low. They also assume that SCL goes low only while the block drives it or while a slave is stretching, and that requests follow a sensible bus order: START from a free bus, and STOP or repeated START only after the block has pulled SCL low. The bench models the lines as wired-AND of the block's enables and a bus model. That model pulls SDA only while SCL is low, releases both lines before every START and STOP, and holds SCL low only once the block has already pulled it low, so the stimulus never leaves those assumptions. Collisions are created deliberately, by holding SDA low across a whole transmitted byte.

// File: rtl/i2c_cmd_master.sv
`timescale 1ns/1ps
module i2c_cmd_master #(
  parameter int BRG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brg_we,
  input  logic [BRG_W-1:0] brg_wdata,
  output logic [BRG_W-1:0] brg_q,
  input  logic             tx_we,
  input  logic [7:0]       tx_wdata,
  output logic [7:0]       tx_q,
  input  logic             rx_re,
  output logic [7:0]       rx_q,
  input  logic             go_start,
  input  logic             go_restart,
  input  logic             go_stop,
  input  logic             go_recv,
  input  logic             go_ack,
  input  logic             ack_level,
  input  logic             flag_clr,
  output logic             start_pend,
  output logic             restart_pend,
  output logic             stop_pend,
  output logic             recv_pend,
  output logic             ack_pend,
  output logic             nack_seen,
  output logic             tx_active,
  output logic             tx_full,
  output logic             rx_full,
  output logic             wr_clash,
  output logic             rx_overrun,
  output logic             bus_clash,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             scl_i,
  input  logic             sda_i
);
  typedef enum logic [2:0] {OP_IDLE, OP_START, OP_RSTART, OP_STOP, OP_TX, OP_RX, OP_ACK} op_t;

  op_t              op;
  logic [1:0]       ph;
  logic [3:0]       bitn;
  logic [BRG_W-1:0] cnt;
  logic [7:0]       sh;
  logic             scl_rel, sda_rel, ack_bit;

  logic idle, stretch, tick, any_go, tx_ok, drv, last, watch;

  assign idle    = (op == OP_IDLE);
  assign stretch = scl_rel & ~scl_i;
  assign tick    = ~idle & (cnt == '0) & ~stretch;
  assign any_go  = go_start | go_restart | go_stop | go_recv | go_ack;
  assign tx_ok   = tx_we & idle & ~any_go;
  assign drv     = (op == OP_TX) ? (bitn[3] | sh[7]) : (op == OP_ACK) ? ack_bit : 1'b1;
  assign last    = (op == OP_TX) ? bitn[3] : (op == OP_RX) ? (bitn == 4'd7) : 1'b1;
  assign watch   = ((op == OP_TX) & ~bitn[3]) | (op == OP_ACK);

  assign start_pend   = (op == OP_START);
  assign restart_pend = (op == OP_RSTART);
  assign stop_pend    = (op == OP_STOP);
  assign recv_pend    = (op == OP_RX);
  assign ack_pend     = (op == OP_ACK);
  assign tx_active    = (op == OP_TX);
  assign scl_oe       = ~scl_rel;
  assign sda_oe       = ~sda_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op <= OP_IDLE;  ph <= '0;  bitn <= '0;  cnt <= '0;  sh <= '0;
      scl_rel <= 1'b1;  sda_rel <= 1'b1;  ack_bit <= 1'b1;
      brg_q <= '0;  tx_q <= 8'hFF;  rx_q <= '0;
      nack_seen <= 1'b0;  tx_full <= 1'b0;  rx_full <= 1'b0;
      wr_clash <= 1'b0;  rx_overrun <= 1'b0;  bus_clash <= 1'b0;
    end else begin
      if (brg_we) brg_q <= brg_wdata;
      if (idle || tick) cnt <= brg_q;
      else if (!stretch) cnt <= cnt - BRG_W'(1);

      if (flag_clr) begin
        wr_clash <= 1'b0;  rx_overrun <= 1'b0;  bus_clash <= 1'b0;
      end
      if (rx_re) rx_full <= 1'b0;
      if (tx_we && !tx_ok) wr_clash <= 1'b1;

      if (idle) begin
        ph <= '0;
        bitn <= '0;
        if (go_start)        op <= OP_START;
        else if (go_restart) op <= OP_RSTART;
        else if (go_stop)    op <= OP_STOP;
        else if (go_recv)    op <= OP_RX;
        else if (go_ack) begin
          op <= OP_ACK;
          ack_bit <= ack_level;
        end else if (tx_we) begin
          op <= OP_TX;
          tx_q <= tx_wdata;
          sh <= tx_wdata;
          tx_full <= 1'b1;
        end
      end else if (tick) begin
        case (op)
          OP_START: begin
            if (ph == 2'd0) sda_rel <= 1'b0;
            else begin scl_rel <= 1'b0; op <= OP_IDLE; end
            ph <= ph + 2'd1;
          end
          OP_RSTART: begin
            case (ph)
              2'd0: sda_rel <= 1'b1;
              2'd1: scl_rel <= 1'b1;
              2'd2: sda_rel <= 1'b0;
              default: begin scl_rel <= 1'b0; op <= OP_IDLE; end
            endcase
            ph <= ph + 2'd1;
          end
          OP_STOP: begin
            case (ph)
              2'd0: sda_rel <= 1'b0;
              2'd1: scl_rel <= 1'b1;
              default: begin sda_rel <= 1'b1; op <= OP_IDLE; end
            endcase
            ph <= ph + 2'd1;
          end
          OP_TX, OP_RX, OP_ACK: begin
            case (ph)
              2'd0: begin sda_rel <= drv; ph <= 2'd1; end
              2'd1: begin scl_rel <= 1'b1; ph <= 2'd2; end
              default: begin
                scl_rel <= 1'b0;
                ph <= 2'd0;
                bitn <= bitn + 4'd1;
                if (watch && sda_rel && !sda_i) bus_clash <= 1'b1;
                if (op == OP_TX && !bitn[3]) sh <= {sh[6:0], 1'b0};
                if (op == OP_TX && bitn == 4'd7) tx_full <= 1'b0;
                if (op == OP_TX && bitn[3]) nack_seen <= sda_i;
                if (op == OP_RX) sh <= {sh[6:0], sda_i};
                if (op == OP_RX && bitn == 4'd7) begin
                  rx_q <= {sh[6:0], sda_i};
                  rx_full <= 1'b1;
                  if (rx_full && !rx_re) rx_overrun <= 1'b1;
                end
                if (last) op <= OP_IDLE;
              end
            endcase
          end
          default: op <= OP_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_master_chk.sv
`timescale 1ns/1ps
module i2c_cmd_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_we,
  input logic       rx_re,
  input logic [7:0] tx_q,
  input logic       start_pend,
  input logic       stop_pend,
  input logic       recv_pend,
  input logic       tx_active,
  input logic       tx_full,
  input logic       rx_full,
  input logic       wr_clash,
  input logic       rx_overrun,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       scl_i
);
  p_start_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_pend) |-> (scl_oe && sda_oe));

  p_stop_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_pend) |-> (!scl_oe && !sda_oe));

  p_load_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> tx_full);

  p_sent_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> !tx_full);

  p_sda_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !$stable(sda_oe)) |-> scl_oe);

  p_byte_arrives_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(recv_pend));

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_re && !recv_pend) |=> !rx_full);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> ($past(rx_full) && $past(recv_pend)));

  p_busy_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_we && tx_active) |=> (wr_clash && $stable(tx_q)));

  p_stretch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !scl_i) |=> (!scl_oe && $stable(sda_oe)));
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_we(tx_we), .rx_re(rx_re), .tx_q(tx_q),
  .start_pend(start_pend), .stop_pend(stop_pend), .recv_pend(recv_pend),
  .tx_active(tx_active), .tx_full(tx_full), .rx_full(rx_full),
  .wr_clash(wr_clash), .rx_overrun(rx_overrun),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_i(scl_i)
);

// File: tb/i2c_cmd_master_test.sv
`timescale 1ns/1ps
module i2c_cmd_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic brg_we = 0, tx_we = 0, rx_re = 0, flag_clr = 0, ack_level = 0;
  logic go_start = 0, go_restart = 0, go_stop = 0, go_recv = 0, go_ack = 0;
  logic [7:0] brg_wdata = 0, tx_wdata = 0;
  logic [7:0] brg_q, tx_q, rx_q;
  logic start_pend, restart_pend, stop_pend, recv_pend, ack_pend;
  logic nack_seen, tx_active, tx_full, rx_full, wr_clash, rx_overrun, bus_clash;
  logic scl_oe, sda_oe, scl_i, sda_i;
  logic stretch_low = 0, slv_low = 0, jam = 0, sack = 1, mon_on = 0;
  logic [7:0] sbyte = 0, exp_rx = 0;
  logic [8:0] mon_sh = 0;
  logic [6:0] snap = 0;
  logic [9:0] expq[$];
  int smode = 0, bitcnt = 0, vectors = 0, miscompares = 0;
  string req = "R1";
  wire busy = start_pend | restart_pend | stop_pend | recv_pend | ack_pend | tx_active;

  assign scl_i = ~scl_oe & ~stretch_low;
  assign sda_i = ~sda_oe & ~slv_low & ~jam;

  always #4 clk = ~clk;

  i2c_cmd_master #(.BRG_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .brg_we(brg_we), .brg_wdata(brg_wdata), .brg_q(brg_q),
    .tx_we(tx_we), .tx_wdata(tx_wdata), .tx_q(tx_q), .rx_re(rx_re), .rx_q(rx_q),
    .go_start(go_start), .go_restart(go_restart), .go_stop(go_stop), .go_recv(go_recv),
    .go_ack(go_ack), .ack_level(ack_level), .flag_clr(flag_clr),
    .start_pend(start_pend), .restart_pend(restart_pend), .stop_pend(stop_pend),
    .recv_pend(recv_pend), .ack_pend(ack_pend), .nack_seen(nack_seen),
    .tx_active(tx_active), .tx_full(tx_full), .rx_full(rx_full), .wr_clash(wr_clash),
    .rx_overrun(rx_overrun), .bus_clash(bus_clash), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .scl_i(scl_i), .sda_i(sda_i));

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic got(input logic [9:0] ev);
    logic [9:0] e;
    vectors++;
    if (expq.size() == 0) begin
      miscompares++;
      $display("FAIL %s: bus event got %0h expected none", req, ev);
    end else begin
      e = expq.pop_front();
      if (ev !== e) begin
        miscompares++;
        $display("FAIL %s: bus event got %0h expected %0h", req, ev, e);
      end
    end
  endtask

  // monitor: events are 10'h200 START, 10'h201 STOP, {1'b0, ack, data} byte
  always @(posedge scl_i) if (mon_on) begin
    mon_sh = {mon_sh[7:0], sda_i};
    bitcnt++;
    if (bitcnt == 9) begin
      got({1'b0, mon_sh[0], mon_sh[8:1]});
      bitcnt = 0;
    end
  end
  always @(negedge sda_i) if (mon_on && scl_i) begin got(10'h200); bitcnt = 0; end
  always @(posedge sda_i) if (mon_on && scl_i) got(10'h201);

  // bus slave: drives SDA only after SCL falls
  always @(negedge scl_i) if (mon_on) begin
    if (smode == 1)      slv_low = (bitcnt == 8) && sack;
    else if (smode == 2) slv_low = (bitcnt < 8) && !sbyte[7 - bitcnt];
    else                 slv_low = 1'b0;
  end

  // kind: 0 start, 1 restart, 2 stop, 3 receive, 4 acknowledge, 5 transmit
  task automatic run(input int kind, input logic [7:0] d, output int n);
    case (kind)
      0, 1: begin smode = 0; slv_low = 0; expq.push_back(10'h200); end
      2:    begin smode = 0; slv_low = 0; expq.push_back(10'h201); end
      3:    begin smode = 2; slv_low = !sbyte[7]; end
      4:    expq.push_back({1'b0, d[0], exp_rx});
      default: begin
        smode = 1; slv_low = 0;
        expq.push_back({1'b0, !(sack | jam), d & {8{~jam}}});
      end
    endcase
    @(negedge clk);
    case (kind)
      0: go_start = 1;
      1: go_restart = 1;
      2: go_stop = 1;
      3: go_recv = 1;
      4: begin go_ack = 1; ack_level = d[0]; end
      default: begin tx_we = 1; tx_wdata = d; end
    endcase
    @(negedge clk);
    go_start = 0; go_restart = 0; go_stop = 0; go_recv = 0; go_ack = 0; tx_we = 0;
    snap = {start_pend, restart_pend, stop_pend, recv_pend, ack_pend, tx_active, tx_full};
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int n, hn;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    mon_on = 1;
    // R1 reset state
    check("R1 lines", {scl_oe, sda_oe}, 0);
    check("R1 regs", {brg_q, tx_q, rx_q}, 24'h00FF00);
    check("R1 flags", {start_pend, restart_pend, stop_pend, recv_pend, ack_pend, nack_seen,
                       tx_active, tx_full, rx_full, wr_clash, rx_overrun, bus_clash}, 0);

    // R11 preset write: P = 2, step = 3 cycles
    brg_wdata = 8'd2; brg_we = 1; @(negedge clk); brg_we = 0;
    check("R11 preset", brg_q, 8'd2);

    req = "R2"; run(0, 0, n);
    check("R2 pend seen", snap[6], 1);
    check("R2 duration", n, 6);
    check("R2 lines held", {scl_oe, sda_oe}, 2'b11);

    req = "R3"; sack = 1; run(5, 8'hA6, n);
    check("R3 active+full", snap[1:0], 2'b11);
    check("R3 duration", n, 81);
    check("R3 tx reg", tx_q, 8'hA6);
    check("R3 full cleared", tx_full, 0);
    check("R4 ack", nack_seen, 0);
    check("R10 no clash", bus_clash, 0);

    req = "R4"; sack = 0; run(5, 8'h3C, n);
    check("R4 nack", nack_seen, 1);

    // R8 write while busy, R13 stop request while busy
    req = "R8"; sack = 1;
    fork
      run(5, 8'h5A, n);
      begin
        repeat (10) @(negedge clk);
        tx_we = 1; tx_wdata = 8'h11; @(negedge clk); tx_we = 0;
        repeat (5) @(negedge clk);
        go_stop = 1; @(negedge clk); go_stop = 0;
        check("R13 stop ignored", stop_pend, 0);
      end
    join
    check("R8 clash flag", wr_clash, 1);
    check("R8 tx reg kept", tx_q, 8'h5A);
    check("R13 still idle", busy, 0);
    pulse_clr();
    check("R12 clash cleared", wr_clash, 0);

    req = "R7"; run(1, 0, n);
    check("R7 restart duration", n, 12);
    check("R7 restart pend", snap[5], 1);
    req = "R3"; run(5, 8'hA7, n);

    req = "R5"; sbyte = 8'hC5; run(3, 0, n);
    check("R5 pend seen", snap[3], 1);
    check("R5 duration", n, 72);
    check("R5 data", rx_q, 8'hC5);
    check("R5 full", rx_full, 1);
    req = "R6"; exp_rx = 8'hC5; run(4, 8'h00, n);
    check("R6 duration", n, 9);
    check("R9 no overrun yet", rx_overrun, 0);

    req = "R9"; sbyte = 8'h39; run(3, 0, n);
    check("R9 overrun", rx_overrun, 1);
    check("R9 new byte kept", rx_q, 8'h39);
    req = "R6"; exp_rx = 8'h39; run(4, 8'h01, n);
    @(negedge clk); rx_re = 1; @(negedge clk); rx_re = 0;
    check("R5 read clears", rx_full, 0);

    req = "R7"; run(2, 0, n);
    check("R7 stop duration", n, 9);
    check("R7 lines free", {scl_oe, sda_oe}, 2'b00);
    pulse_clr();
    check("R12 overrun cleared", rx_overrun, 0);

    // R10 collision: SDA held low across a byte of ones
    req = "R10"; run(0, 0, n);
    jam = 1; run(5, 8'hFF, n); jam = 0;
    check("R10 clash", bus_clash, 1);
    req = "R7"; run(2, 0, n);
    pulse_clr();
    check("R12 bus clash cleared", bus_clash, 0);

    // R11 stretch with P = 4
    brg_wdata = 8'd4; brg_we = 1; @(negedge clk); brg_we = 0;
    req = "R11"; run(0, 0, n);
    stretch_low = 1;
    fork
      run(5, 8'h81, n);
      begin
        repeat (15) @(negedge clk);
        check("R11 released in stretch", scl_oe, 0);
        repeat (10) @(negedge clk);
        stretch_low = 0;
      end
      begin
        @(posedge scl_i); @(negedge scl_i); @(posedge scl_i);
        hn = 0;
        while (scl_i) begin @(negedge clk); if (scl_i) hn++; end
      end
    join
    check("R11 high phase", hn, 5);
    check("R11 stretched longer", n > 135, 1);
    req = "R7"; run(2, 0, n);

    repeat (20) @(negedge clk);
    check("R3 all bus events seen", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule